// File: doc/BRIEF.md
# Multicast Hash Address Filter

This block decides whether an incoming frame should be kept, based only on its six-byte destination address. The address arrives as a byte stream, first byte first. While the bytes go past, the block does three things at once. It compares them with a programmed station address. It checks whether every byte is all ones, which marks the broadcast address. It also runs a bit-serial CRC-32 over them, and the top six CRC bits become a hash.

For a multicast destination, the hash picks one bit of a 64-bit filter, and the frame is kept only if that bit is set. For a unicast destination, the address must equal the station address. Broadcast frames are always kept. A promiscuous control keeps every frame.

A start strobe opens each frame. The decision is presented for one cycle, one cycle after the sixth byte is taken. Parsing beyond the destination address belongs to other logic.

Top module: `mhf_filter`

## Requirements
- R1: The hash is bits 31:26 of a CRC-32 that starts at 0xFFFFFFFF and uses the reflected polynomial 0xEDB88320. Each byte is consumed least-significant bit first. For each bit, the CRC shifts right by one and is then XORed with the polynomial if the input bit XOR the old CRC bit 0 was 1. There is no final inversion.
- R2: An address whose first received byte has bit 0 = 1 is multicast. It is accepted exactly when filter bit `filter_i[16*h[5:4] + h[3:0]]` is 1, where h is the hash. In other words, 16-bit word h[5:4] is selected, then bit h[3:0] within that word.
- R3: With `filter_i` all ones, every multicast address is accepted.
- R4: An address whose first byte has bit 0 = 0 is accepted exactly when all six bytes equal `station_addr_i`. Received byte i (i = 0 first) is compared with `station_addr_i[8*i+7:8*i]`. The filter has no effect on unicast addresses.
- R5: The address FF:FF:FF:FF:FF:FF is always accepted, even with an all-zero filter.
- R6: When `promisc_i` is 1 at the sixth byte, the frame is accepted whatever its address.
- R7: `accept_valid_o` is 1 for exactly one cycle, namely the cycle after the one in which the sixth byte is taken. Idle cycles between bytes are allowed. `accept_o` holds its value until the next decision.
- R8: `start_i` discards any partial frame and restarts the CRC and the byte count. A byte presented in the same cycle as `start_i` is ignored.
- R9: Bytes presented after the sixth and before the next `start_i` are ignored. They produce no new `accept_valid_o` pulse, and `accept_o` does not change.
- R10: After reset, `accept_valid_o` and `accept_o` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start of a new destination address |
| byte_valid_i | input | 1 | `byte_i` holds an address byte this cycle |
| byte_i | input | 8 | Address byte, first received byte first |
| promisc_i | input | 1 | Accept every frame |
| station_addr_i | input | 48 | Station address, received byte i at bits 8i+7:8i |
| filter_i | input | 64 | Hash filter, four 16-bit words |
| accept_valid_o | output | 1 | One-cycle decision strobe |
| accept_o | output | 1 | Decision; 1 = keep the frame |

## Verification
The hardest case to reach from the ports is proof that the hash selects exactly the intended filter bit, and not a neighbour. That depends on the full 48-bit CRC being right. The bench computes the CRC of each multicast address on its own side. It then programs a filter with only the computed bit set, and expects acceptance. Next it programs a filter with only the adjacent bit set, and expects rejection. A wrong bit order, seed, word select or bit select therefore moves the decision.

// File: rtl/mhf_pkg.sv
// Package: shared constants and the byte-wide CRC step for the hash filter.
// Assumes bytes are consumed least-significant bit first.
package mhf_pkg;
    localparam int          BYTE_W    = 8;
    localparam int          CRC_W     = 32;
    localparam logic [31:0] CRC_POLY  = 32'hEDB88320;
    localparam logic [31:0] CRC_SEED  = 32'hFFFFFFFF;

    // Advance the reflected CRC by one byte, LSB first.
    function automatic logic [CRC_W-1:0] crc_step_byte(input logic [CRC_W-1:0] c_in,
                                                      input logic [BYTE_W-1:0] d);
        logic [CRC_W-1:0] c;
        logic             fb;
        c = c_in;
        for (int i = 0; i < BYTE_W; i++) begin
            fb = c[0] ^ d[i];
            c  = c >> 1;
            if (fb) c = c ^ CRC_POLY;
        end
        return c;
    endfunction
endpackage

// File: rtl/mhf_crc_engine.sv
// CRC engine: holds the running CRC of the current address.
// It presents the hash of the CRC that includes the byte being loaded this cycle.
// Assumes clear_i has priority over load_i.
module mhf_crc_engine #(
    parameter int HASH_BITS = 6
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        clear_i,
    input  logic                        load_i,
    input  logic [mhf_pkg::BYTE_W-1:0]  data_i,
    output logic [HASH_BITS-1:0]        hash_o
);
    import mhf_pkg::*;

    logic [CRC_W-1:0] crc_q;
    logic [CRC_W-1:0] crc_next;

    // Next CRC value with the current byte folded in.
    always_comb crc_next = crc_step_byte(crc_q, data_i);

    assign hash_o = crc_next[CRC_W-1 -: HASH_BITS];

    // Running CRC register: seeded on clear, advanced on each taken byte.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) crc_q <= CRC_SEED;
        else if (load_i)       crc_q <= crc_next;
    end

    // R8
    crc_seed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> crc_q == CRC_SEED);
    // R1
    crc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && !load_i) |=> $stable(crc_q));
endmodule

// File: rtl/mhf_addr_track.sv
// Address tracker: counts taken bytes and keeps running flags for
// station-address match, all-ones match and the multicast marker.
// It presents the flag values that include the current byte.
// Assumes start_i has priority over byte_valid_i.
module mhf_addr_track #(
    parameter int N_BYTES = 6,
    localparam int CNT_W  = $clog2(N_BYTES + 1),
    localparam int ADDR_W = N_BYTES * mhf_pkg::BYTE_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start_i,
    input  logic                        byte_valid_i,
    input  logic [mhf_pkg::BYTE_W-1:0]  byte_i,
    input  logic [ADDR_W-1:0]           station_i,
    output logic                        take_o,
    output logic                        last_o,
    output logic                        uni_next_o,
    output logic                        bc_next_o,
    output logic                        mc_next_o
);
    import mhf_pkg::*;

    localparam logic [CNT_W-1:0] FULL = CNT_W'(N_BYTES);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(N_BYTES - 1);

    logic [CNT_W-1:0]  cnt_q;
    logic              uni_q, bc_q, mc_q;
    logic [BYTE_W-1:0] exp_byte;

    // Station byte expected at the current position.
    always_comb begin
        exp_byte = '0;
        for (int i = 0; i < N_BYTES; i++)
            if (cnt_q == CNT_W'(i)) exp_byte = station_i[i*BYTE_W +: BYTE_W];
    end

    // Byte acceptance and the flag values that include this byte.
    always_comb begin
        take_o     = byte_valid_i && !start_i && (cnt_q < FULL);
        last_o     = take_o && (cnt_q == LAST);
        uni_next_o = uni_q && (byte_i == exp_byte);
        bc_next_o  = bc_q && (byte_i == {BYTE_W{1'b1}});
        mc_next_o  = (cnt_q == '0) ? byte_i[0] : mc_q;
    end

    // Count and flag registers, restarted by start_i.
    always_ff @(posedge clk) begin
        if (!rst_n || start_i) begin
            cnt_q <= '0;
            uni_q <= 1'b1;
            bc_q  <= 1'b1;
            mc_q  <= 1'b0;
        end else if (take_o) begin
            cnt_q <= cnt_q + 1'b1;
            uni_q <= uni_next_o;
            bc_q  <= bc_next_o;
            mc_q  <= mc_next_o;
        end
    end

    // R9
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= FULL);
    // R8
    start_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> cnt_q == '0);
    // R9
    full_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == FULL && !start_i) |=> cnt_q == FULL);
endmodule

// File: rtl/mhf_decide.sv
// Decision stage: combines the flags, promiscuous control and the hash-selected
// filter bit. It registers the accept result and a one-cycle valid strobe.
// Assumes done_i is high for exactly one cycle per address.
module mhf_decide #(
    parameter int HASH_BITS = 6,
    parameter int WORD_W    = 16,
    localparam int FILT_W   = 1 << HASH_BITS,
    localparam int BIT_SEL  = $clog2(WORD_W)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  done_i,
    input  logic                  promisc_i,
    input  logic                  uni_i,
    input  logic                  bc_i,
    input  logic                  mc_i,
    input  logic [FILT_W-1:0]     filter_i,
    input  logic [HASH_BITS-1:0]  hash_i,
    output logic                  valid_o,
    output logic                  accept_o
);
    logic [WORD_W-1:0] word_sel;
    logic              hash_hit;
    logic              verdict;

    // Pick the filter word from the upper hash bits, then the bit from the lower.
    always_comb begin
        word_sel = filter_i[hash_i[HASH_BITS-1:BIT_SEL] * WORD_W +: WORD_W];
        hash_hit = word_sel[hash_i[BIT_SEL-1:0]];
        verdict  = promisc_i || bc_i || (mc_i ? hash_hit : uni_i);
    end

    // Decision register and strobe; accept_o holds between decisions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o  <= 1'b0;
            accept_o <= 1'b0;
        end else begin
            valid_o <= done_i;
            if (done_i) accept_o <= verdict;
        end
    end

    // R7
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);
    // R7
    valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |=> valid_o);
    // R6
    promisc_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && promisc_i) |=> accept_o);
    // R5
    bcast_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && bc_i) |=> accept_o);
    // R9
    accept_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_i |=> $stable(accept_o));
endmodule

// File: rtl/mhf_filter.sv
// Top: destination-address filter. Streams six address bytes through a CRC
// hash, a station-address comparator and a broadcast detector, then issues one
// accept decision. Assumes start_i precedes every address.
module mhf_filter #(
    parameter int N_BYTES   = 6,
    parameter int HASH_BITS = 6,
    parameter int WORD_W    = 16,
    localparam int ADDR_W   = N_BYTES * mhf_pkg::BYTE_W,
    localparam int FILT_W   = 1 << HASH_BITS
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start_i,
    input  logic                        byte_valid_i,
    input  logic [mhf_pkg::BYTE_W-1:0]  byte_i,
    input  logic                        promisc_i,
    input  logic [ADDR_W-1:0]           station_addr_i,
    input  logic [FILT_W-1:0]           filter_i,
    output logic                        accept_valid_o,
    output logic                        accept_o
);
    logic                 take, last, uni_n, bc_n, mc_n;
    logic [HASH_BITS-1:0] hash;

    mhf_addr_track #(.N_BYTES(N_BYTES)) u_track (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .byte_valid_i(byte_valid_i), .byte_i(byte_i), .station_i(station_addr_i),
        .take_o(take), .last_o(last), .uni_next_o(uni_n),
        .bc_next_o(bc_n), .mc_next_o(mc_n)
    );

    mhf_crc_engine #(.HASH_BITS(HASH_BITS)) u_crc (
        .clk(clk), .rst_n(rst_n), .clear_i(start_i), .load_i(take),
        .data_i(byte_i), .hash_o(hash)
    );

    mhf_decide #(.HASH_BITS(HASH_BITS), .WORD_W(WORD_W)) u_decide (
        .clk(clk), .rst_n(rst_n), .done_i(last), .promisc_i(promisc_i),
        .uni_i(uni_n), .bc_i(bc_n), .mc_i(mc_n), .filter_i(filter_i),
        .hash_i(hash), .valid_o(accept_valid_o), .accept_o(accept_o)
    );
endmodule

// File: tb/mhf_filter_test.sv
`timescale 1ns/1ps
module mhf_filter_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        byte_valid_i = 1'b0;
    logic [7:0]  byte_i = '0;
    logic        promisc_i = 1'b0;
    logic [47:0] station_addr_i = 48'h554433221102;
    logic [63:0] filter_i = '0;
    logic        accept_valid_o, accept_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    mhf_filter uut (.*);

    always #2.5 clk = ~clk;

    // Reference hash: CRC-32 over all 48 bits, LSB of first byte first.
    function automatic logic [5:0] ref_hash(input logic [47:0] a);
        logic [31:0] c = 32'hFFFFFFFF;
        for (int k = 0; k < 48; k++) begin
            if ((c[0] ^ a[k]) == 1'b1) c = (c >> 1) ^ 32'hEDB88320;
            else                       c = c >> 1;
        end
        return c[31:26];
    endfunction

    task automatic check(input string req, input logic got, input logic exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0b expected %0b", req, got, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk); start_i = 1'b1;
        @(posedge clk); #1 start_i = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk); byte_valid_i = 1'b1; byte_i = b;
        @(posedge clk); #1 byte_valid_i = 1'b0;
    endtask

    // Full frame; checks the strobe cycle, its value, and the strobe drop after.
    task automatic run_frame(input logic [47:0] a, input logic exp, input string req);
        pulse_start();
        for (int i = 0; i < 6; i++) send_byte(a[i*8 +: 8]);
        @(negedge clk);
        check({req, " strobe"}, accept_valid_o, 1'b1);
        check(req, accept_o, exp);
        @(negedge clk);
        check("R7 one-cycle strobe", accept_valid_o, 1'b0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R10 valid after reset", accept_valid_o, 1'b0);
        check("R10 accept after reset", accept_o, 1'b0);
    endtask

    task automatic t_unicast();
        filter_i = '0;
        run_frame(48'h554433221102, 1'b1, "R4 station match");
        run_frame(48'h564433221102, 1'b0, "R4 last byte differs");
        filter_i = '1;
        run_frame(48'h554433231102, 1'b0, "R4 filter ignored for unicast");
    endtask

    task automatic t_hash(input logic [47:0] a);
        logic [5:0] h = ref_hash(a);
        filter_i = 64'b1 << h;
        run_frame(a, 1'b1, "R1 R2 hash bit set");
        filter_i = 64'b1 << (h ^ 6'd1);
        run_frame(a, 1'b0, "R1 R2 neighbour bit only");
        filter_i = ~(64'b1 << h);
        run_frame(a, 1'b0, "R2 only own bit clear");
    endtask

    task automatic t_allones();
        filter_i = '1;
        run_frame(48'h0000005E0001, 1'b1, "R3 all-ones filter");
        run_frame(48'hABCDEF123433, 1'b1, "R3 all-ones filter 2");
    endtask

    task automatic t_bcast();
        filter_i = '0;
        run_frame(48'hFFFFFFFFFFFF, 1'b1, "R5 broadcast");
    endtask

    task automatic t_promisc();
        filter_i = '0;
        promisc_i = 1'b1;
        run_frame(48'h123456789A00, 1'b1, "R6 promisc unicast");
        run_frame(48'h123456789A01, 1'b1, "R6 promisc multicast");
        promisc_i = 1'b0;
    endtask

    task automatic t_gaps();
        pulse_start();
        for (int i = 0; i < 6; i++) begin
            repeat (2) @(negedge clk);
            send_byte(station_addr_i[i*8 +: 8]);
        end
        @(negedge clk);
        check("R7 strobe with gaps", accept_valid_o, 1'b1);
        check("R7 accept with gaps", accept_o, 1'b1);
    endtask

    task automatic t_extra();
        filter_i = '0;
        run_frame(48'h554433221102, 1'b1, "R9 setup");
        send_byte(8'h01); send_byte(8'h00); send_byte(8'h00);
        send_byte(8'h00); send_byte(8'h00); send_byte(8'h00);
        @(negedge clk);
        check("R9 no strobe for extra bytes", accept_valid_o, 1'b0);
        check("R9 accept unchanged", accept_o, 1'b1);
    endtask

    task automatic t_restart();
        filter_i = '0;
        pulse_start();
        send_byte(8'h02); send_byte(8'h11); send_byte(8'h99);
        // start with a byte in the same cycle: the byte must be ignored
        @(negedge clk); start_i = 1'b1; byte_valid_i = 1'b1; byte_i = 8'h77;
        @(posedge clk); #1 start_i = 1'b0; byte_valid_i = 1'b0;
        for (int i = 0; i < 6; i++) send_byte(station_addr_i[i*8 +: 8]);
        @(negedge clk);
        check("R8 strobe after restart", accept_valid_o, 1'b1);
        check("R8 restart discards partial and same-cycle byte", accept_o, 1'b1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_unicast();
        t_hash(48'h0000005E0001);
        t_hash(48'hC0FFEE123433);
        t_allones();
        t_bcast();
        t_promisc();
        t_gaps();
        t_extra();
        t_restart();
        done = 1;
    end

    initial begin
        for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule